// File: doc/BRIEF.md
# Key-Guarded Sequence Table

This block stores sixteen instruction sequences of four 32-bit words each, 64 words in all, on behalf of a flash sequencer. Software reaches the table and two control registers through a simple register bus of valid, write flag, byte address and write data, with read data returned one cycle after a read request. A second, purely combinational port lets the sequencer fetch all four words of one sequence at once.

The table can only be changed while it is open. Opening and closing are each a two-write ritual: the magic key 0x5AF05AF0 goes to the key register and the very next bus write must be a command to the guard register. Any other write in between, or a wrong key, cancels the ritual. The table starts closed after reset with every word cleared, so software opens it, writes the four words of a sequence and closes it again.

Top module: `lut_key_table`

## Requirements
- R1: After reset the table is locked, every table word reads 0 on the bus and on the sequencer port, and a read of the guard register (byte offset 0x004) returns 0x00000001.
- R2: A write of 0x5AF05AF0 to the key register (byte offset 0x000) directly followed by a write of a value whose bits [1:0] are 2'b10 to the guard register unlocks the table; the guard register then reads 0x00000002.
- R3: A write of 0x5AF05AF0 to the key register directly followed by a guard write whose bits [1:0] are 2'b01 locks the table; the guard register then reads 0x00000001.
- R4: While unlocked, a write to byte address 0x100 + s*16 + w*4 stores word w of sequence s, and a bus read of that address returns it with the response valid flag high in the cycle after the read request.
- R5: While locked, table writes are discarded with no effect on any stored word, and table reads still return the stored contents.
- R6: Any bus write other than the correct key, including a wrong key value or a table write, placed between the key write and the guard write leaves the guard write without effect.
- R7: A guard write with bits [1:0] equal to 2'b00 or 2'b11 changes nothing but uses up the armed key, so an immediately following guard write also has no effect.
- R8: The sequencer port returns words 3..2..1..0 of the selected sequence packed from most to least significant, and shows a table write from the cycle after it is accepted.
- R9: Bus reads placed between the key write and the guard write do not cancel the armed key.
- R10: Reads of the key register and of any unmapped address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| seq_sel | input | 4 | Sequence chosen by the sequencer |
| seq_words | output | 128 | Four words of the chosen sequence |

## Verification
A bus write into the table and a sequencer fetch of the same sequence can fall in the same cycle, and so can a guard command and the sequencer fetch of words it would have protected. The bench keeps `seq_sel` pointing at the sequence being written during both directed and random writes, and after every operation compares the sequencer port against a bench model that applies the write only when the model says the table was open before that write. The fetch must show the old word in the write cycle and the new one in the next cycle.

// File: rtl/lut_key_pkg.sv
package lut_key_pkg;
    localparam int unsigned DATA_W    = 32;
    localparam logic [31:0] KEY_VALUE = 32'h5AF0_5AF0;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_KEY  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_TBL  = 2'd3
    } bus_sel_e;
endpackage

// File: rtl/lut_bus_decode.sv
module lut_bus_decode
    import lut_key_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned IDX_W   = 6,
    parameter int unsigned KEY_OFS = 0,
    parameter int unsigned CTL_OFS = 4,
    parameter int unsigned TBL_OFS = 256
) (
    input  logic [ADDR_W-1:0] addr,
    output bus_sel_e          sel,
    output logic [IDX_W-1:0]  idx
);
    localparam int unsigned TOP_LSB = IDX_W + 2;
    localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(KEY_OFS);
    localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_OFS);
    localparam logic [ADDR_W-TOP_LSB-1:0] TBL_PAGE = (ADDR_W-TOP_LSB)'(TBL_OFS >> TOP_LSB);

    always_comb begin
        idx = addr[TOP_LSB-1:2];
        if (addr == KEY_A) begin
            sel = SEL_KEY;
        end else if (addr == CTL_A) begin
            sel = SEL_CTRL;
        end else if (addr[ADDR_W-1:TOP_LSB] == TBL_PAGE && addr[1:0] == 2'b00) begin
            sel = SEL_TBL;
        end else begin
            sel = SEL_NONE;
        end
    end
endmodule

// File: rtl/lut_key_guard.sv
module lut_key_guard
    import lut_key_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              key_sel,
    input  logic              ctrl_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic              locked
);
    typedef struct packed {
        logic locked;
        logic armed;
    } guard_t;

    guard_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.armed = key_sel && (wdata == KEY_VALUE);
            if (ctrl_sel && st_q.armed) begin
                case (wdata[1:0])
                    2'b01:   st_d.locked = 1'b1;
                    2'b10:   st_d.locked = 1'b0;
                    default: st_d.locked = st_q.locked;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.locked <= 1'b1;
            st_q.armed  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked = st_q.locked;

    // R6
    disarm_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !key_sel) |=> !st_q.armed);

    // R2
    lock_change_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.locked != $past(st_q.locked)) |-> $past(wr_en && ctrl_sel && st_q.armed));

    // R7
    bad_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ctrl_sel && (wdata[1:0] == 2'b00 || wdata[1:0] == 2'b11)) |=> $stable(st_q.locked));
endmodule

// File: rtl/lut_table_store.sv
module lut_table_store
    import lut_key_pkg::*;
#(
    parameter int unsigned NSEQ  = 16,
    parameter int unsigned NWORD = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [$clog2(NSEQ*NWORD)-1:0] widx,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [$clog2(NSEQ*NWORD)-1:0] ridx,
    output logic [DATA_W-1:0]             rdata,
    input  logic [$clog2(NSEQ)-1:0]       seq_sel,
    output logic [NWORD*DATA_W-1:0]       seq_words
);
    localparam int unsigned DEPTH = NSEQ * NWORD;
    localparam int unsigned IDX_W = $clog2(DEPTH);
    localparam int unsigned WSL_W = $clog2(NWORD);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] words;
    } store_t;

    store_t st_d, st_q;
    logic [IDX_W-1:0] seq_base;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.words[widx] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign seq_base  = {seq_sel, {WSL_W{1'b0}}};
    assign rdata     = st_q.words[ridx];

    generate
        for (genvar w = 0; w < NWORD; w++) begin : g_seq_word
            assign seq_words[w*DATA_W +: DATA_W] = st_q.words[seq_base + IDX_W'(w)];
        end
    endgenerate

    // R4
    store_land_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (st_q.words[$past(widx)] == $past(wdata)));
endmodule

// File: rtl/lut_key_table.sv
module lut_key_table
    import lut_key_pkg::*;
#(
    parameter int unsigned NSEQ   = 16,
    parameter int unsigned NWORD  = 4,
    parameter int unsigned ADDR_W = 12
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [31:0]                   req_wdata,
    output logic                          rsp_valid,
    output logic [31:0]                   rsp_rdata,
    input  logic [$clog2(NSEQ)-1:0]       seq_sel,
    output logic [NWORD*32-1:0]           seq_words
);
    localparam int unsigned DEPTH = NSEQ * NWORD;
    localparam int unsigned IDX_W = $clog2(DEPTH);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rsp_t;

    bus_sel_e          sel;
    logic [IDX_W-1:0]  idx;
    logic              wr_en;
    logic              locked;
    logic              tbl_we;
    logic [DATA_W-1:0] tbl_rdata;
    rsp_t              rsp_d, rsp_q;

    assign wr_en = req_valid && req_write;

    lut_bus_decode #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_decode (
        .addr (req_addr),
        .sel  (sel),
        .idx  (idx)
    );

    lut_key_guard u_guard (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .key_sel  (sel == SEL_KEY),
        .ctrl_sel (sel == SEL_CTRL),
        .wdata    (req_wdata),
        .locked   (locked)
    );

    assign tbl_we = wr_en && (sel == SEL_TBL) && !locked;

    lut_table_store #(
        .NSEQ  (NSEQ),
        .NWORD (NWORD)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .we        (tbl_we),
        .widx      (idx),
        .wdata     (req_wdata),
        .ridx      (idx),
        .rdata     (tbl_rdata),
        .seq_sel   (seq_sel),
        .seq_words (seq_words)
    );

    always_comb begin
        rsp_d.valid = req_valid && !req_write;
        rsp_d.data  = '0;
        if (rsp_d.valid) begin
            case (sel)
                SEL_CTRL: rsp_d.data = {30'd0, !locked, locked};
                SEL_TBL:  rsp_d.data = tbl_rdata;
                default:  rsp_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_rdata = rsp_q.data;

    // R4
    rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

    // R10
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> !rsp_valid);
endmodule

// File: tb/lut_key_table_test.sv
module lut_key_table_test;
    localparam int PERIOD = 10;
    localparam logic [31:0] KEY = 32'h5AF0_5AF0;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [11:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic         rsp_valid;
    logic [31:0]  rsp_rdata;
    logic [3:0]   seq_sel = '0;
    logic [127:0] seq_words;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [31:0] m_tbl [64];
    bit          m_locked;
    bit          m_armed;

    lut_key_table uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .seq_sel(seq_sel), .seq_words(seq_words)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [11:0] tbl_addr(int s, int w);
        return 12'(256 + s*16 + w*4);
    endfunction

    function automatic logic [31:0] exp_read(logic [11:0] a);
        if (a == 12'h004) return m_locked ? 32'h1 : 32'h2;
        if (a[11:8] == 4'h1 && a[1:0] == 2'b00) return m_tbl[a[7:2]];
        return 32'h0;
    endfunction

    function automatic logic [127:0] exp_seq(logic [3:0] s);
        return {m_tbl[{s,2'd3}], m_tbl[{s,2'd2}], m_tbl[{s,2'd1}], m_tbl[{s,2'd0}]};
    endfunction

    function automatic void model_write(logic [11:0] a, logic [31:0] d);
        if (a[11:8] == 4'h1 && a[1:0] == 2'b00 && !m_locked) m_tbl[a[7:2]] = d;
        if (a == 12'h004 && m_armed) begin
            if (d[1:0] == 2'b01) m_locked = 1'b1;
            if (d[1:0] == 2'b10) m_locked = 1'b0;
        end
        m_armed = (a == 12'h000) && (d == KEY);
    endfunction

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [11:0] a, logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_read_chk(string req, logic [11:0] a);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, {95'd0, rsp_valid, rsp_rdata}, {95'd0, 1'b1, exp_read(a)});
    endtask

    task automatic seq_chk(string req, logic [3:0] s);
        seq_sel = s;
        #1;
        check(req, seq_words, exp_seq(s));
    endtask

    initial begin
        #(PERIOD*150000);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 64; i++) m_tbl[i] = '0;
        m_locked = 1'b1;
        m_armed  = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        bus_read_chk("R1", 12'h004);
        bus_read_chk("R1", tbl_addr(7, 2));
        seq_chk("R1", 4'd15);

        // R5 locked write discarded, read still works
        bus_write(tbl_addr(3, 1), 32'hDEAD_BEEF);
        bus_read_chk("R5", tbl_addr(3, 1));

        // R2 unlock
        bus_write(12'h000, KEY);
        bus_write(12'h004, 32'h2);
        bus_read_chk("R2", 12'h004);

        // R4 and R8: write all four words while sequencer watches
        seq_sel = 4'd5;
        for (int w = 0; w < 4; w++) begin
            req_valid = 1'b1; req_write = 1'b1;
            req_addr = tbl_addr(5, w); req_wdata = 32'hA500_0000 + 32'(w);
            #1;
            check("R8 same cycle old", seq_words, exp_seq(4'd5));
            @(negedge clk);
            req_valid = 1'b0; req_write = 1'b0;
            model_write(tbl_addr(5, w), 32'hA500_0000 + 32'(w));
            check("R8 next cycle new", seq_words, exp_seq(4'd5));
        end
        check("R8 word order", seq_words, {32'hA500_0003, 32'hA500_0002, 32'hA500_0001, 32'hA500_0000});
        bus_read_chk("R4", tbl_addr(5, 3));

        // R10 key and unmapped reads
        bus_read_chk("R10", 12'h000);
        bus_read_chk("R10", 12'h008);
        bus_read_chk("R10", 12'h102);

        // R3 lock
        bus_write(12'h000, KEY);
        bus_write(12'h004, 32'h1);
        bus_read_chk("R3", 12'h004);

        // R6 table write in between
        bus_write(12'h000, KEY);
        bus_write(tbl_addr(0, 0), 32'h1111_1111);
        bus_write(12'h004, 32'h2);
        bus_read_chk("R6", 12'h004);
        bus_read_chk("R6", tbl_addr(0, 0));

        // R6 wrong key
        bus_write(12'h000, KEY ^ 32'h1);
        bus_write(12'h004, 32'h2);
        bus_read_chk("R6", 12'h004);

        // R9 reads between key and command
        bus_write(12'h000, KEY);
        bus_read_chk("R9", tbl_addr(5, 0));
        bus_read_chk("R9", 12'h004);
        bus_write(12'h004, 32'h2);
        bus_read_chk("R9", 12'h004);

        // R7 both bits set consumes key
        bus_write(12'h000, KEY);
        bus_write(12'h004, 32'h3);
        bus_read_chk("R7", 12'h004);
        bus_write(12'h004, 32'h1);
        bus_read_chk("R7", 12'h004);
        bus_write(12'h000, KEY);
        bus_write(12'h004, 32'h0);
        bus_write(12'h004, 32'h1);
        bus_read_chk("R7", 12'h004);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            int op;
            logic [11:0] a;
            logic [31:0] d;
            op = int'($urandom % 10);
            d  = $urandom;
            a  = tbl_addr(int'($urandom % 16), int'($urandom % 4));
            seq_sel = a[7:4];
            if (op < 3) begin
                bus_write(12'h000, (op == 0) ? d : KEY);
            end else if (op < 5) begin
                bus_write(12'h004, {30'd0, d[1:0]});
            end else if (op < 8) begin
                bus_write(a, d);
                check("R8 random", seq_words, exp_seq(seq_sel));
            end else if (op == 8) begin
                bus_read_chk("R4 random", a);
            end else begin
                bus_read_chk("R2 random", 12'h004);
            end
        end
        for (int s = 0; s < 16; s++) seq_chk("R8 sweep", 4'(s));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule